// File: doc/BRIEF.md
# Coprocessor Instruction Exception Gate

This block sits beside instruction issue and decides, for each decoded coprocessor escape or WAIT instruction, whether the instruction may go ahead or must raise an exception. It looks at three control bits: emulate, monitor-coprocessor and task-switched. It also samples an active-low error line driven by the attached numeric coprocessor. From these it produces exactly one of three registered one-cycle outputs: a "device not available" request (vector 7), a "coprocessor error" request (vector 16), or a proceed pulse.

The emulate bit traps every escape instruction. The monitor and task-switched bits together trap both escapes and WAIT. The error line is consulted only on escapes that decode as error-checking and on WAIT while emulation is off. When a vector 7 condition holds, the error line is not consulted at all.

Neither request carries an error code. A small vector output names the vector being requested, so handler dispatch can use it directly. The error line is taken to be synchronous to the block clock.

Top module: `copgate_top`

## Requirements
- R1: An escape strobe (escStb=1) with emBit=1 gives devNaReq=1 and excVec=7 in the cycle after the strobe.
- R2: An escape or WAIT strobe with mpBit=1 and tsBit=1 gives devNaReq=1 in the cycle after the strobe, whatever emBit is.
- R3: A WAIT strobe with emBit=0, not trapped by R2, and errN=0 gives coprErrReq=1 and excVec=16 in the next cycle. With errN=1 it gives proceed=1.
- R4: An escape with escChkStb=1, not trapped by R1 or R2, gives coprErrReq=1 when errN=0. An escape with escChkStb=0 ignores errN and gives proceed=1.
- R5: A WAIT strobe with emBit=1 and not trapped by R2 ignores errN and gives proceed=1.
- R6: When a vector 7 condition holds, coprErrReq stays 0 even if errN=0 on a pin-testing instruction.
- R7: Every strobed instruction that raises no exception gives proceed=1 in the next cycle.
- R8: At most one of devNaReq, coprErrReq and proceed is 1 in any cycle. Each pulse lasts one cycle per strobe, and a cycle with no strobe leaves all three 0 in the following cycle.
- R9: excVec is 7 while devNaReq=1, 16 while coprErrReq=1, and 0 otherwise.
- R10: A synchronous reset (rst=1) clears devNaReq, coprErrReq, proceed and excVec in the next cycle, whatever the strobes are.
- R11: If escStb and waitStb are both 1 in one cycle, the instruction is judged as an escape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| escStb | input | 1 | Escape instruction starts this cycle |
| waitStb | input | 1 | WAIT instruction starts this cycle |
| escChkStb | input | 1 | The escape tests the coprocessor error line |
| emBit | input | 1 | Emulate control bit |
| mpBit | input | 1 | Monitor-coprocessor control bit |
| tsBit | input | 1 | Task-switched control bit |
| errN | input | 1 | Coprocessor error line, active low |
| devNaReq | output | 1 | One-cycle vector 7 request |
| coprErrReq | output | 1 | One-cycle vector 16 request |
| proceed | output | 1 | One-cycle go-ahead for the instruction |
| excVec | output | 5 | Requested vector number, 0 when none |

## Verification
The bench first sweeps all 128 combinations of strobes, control bits and error-line level, with an idle cycle after each one. This separates the emulate trap from the monitor/task-switched trap. It also shows whether the error line is consulted on checking escapes, on plain escapes, and on WAIT with emulation on and off. Directed sequences then apply back-to-back strobes, to confirm single-cycle pulses with no stretching. They also toggle the error line under a vector 7 condition to expose priority mistakes, and assert reset while strobes are active.

// File: rtl/copgate_pkg.sv
package copgate_pkg;

  // Strobes from the classification control to the output datapath
  typedef struct packed {
    logic instr;     // an instruction is being evaluated this cycle
    logic trapDna;   // a device-not-available condition holds
    logic probePin;  // the error line must be consulted
  } gateStrobe_t;

endpackage

// File: rtl/copgate_ctrl.sv
module copgate_ctrl
  import copgate_pkg::*;
(
  input  logic        escStb,
  input  logic        waitStb,
  input  logic        escChkStb,
  input  logic        emBit,
  input  logic        mpBit,
  input  logic        tsBit,
  output gateStrobe_t strb
);

  logic isEsc;
  logic isWait;
  logic emTrap;
  logic switchTrap;
  logic pinWanted;

  // An escape wins when both class strobes arrive together
  assign isEsc  = escStb;
  assign isWait = waitStb & ~escStb;

  // Emulation traps only escapes; monitor plus task-switched traps both
  assign emTrap     = isEsc & emBit;
  assign switchTrap = (isEsc | isWait) & mpBit & tsBit;

  // Error line is tested on checking escapes and on WAIT without emulation
  assign pinWanted = (isEsc & escChkStb) | (isWait & ~emBit);

  always_comb begin
    strb          = '0;
    strb.instr    = isEsc | isWait;
    strb.trapDna  = emTrap | switchTrap;
    strb.probePin = pinWanted & ~(emTrap | switchTrap);
  end

endmodule

// File: rtl/copgate_dp.sv
module copgate_dp
  import copgate_pkg::*;
#(
  parameter int VEC_W   = 5,
  parameter int DNA_VEC = 7,
  parameter int ERR_VEC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  gateStrobe_t      strb,
  input  logic             errN,
  output logic             devNaReq,
  output logic             coprErrReq,
  output logic             proceed,
  output logic [VEC_W-1:0] excVec
);

  localparam logic [VEC_W-1:0] DnaCode = VEC_W'(DNA_VEC);
  localparam logic [VEC_W-1:0] ErrCode = VEC_W'(ERR_VEC);

  logic             pinFault;
  logic             nxtDna;
  logic             nxtErr;
  logic             nxtGo;
  logic [VEC_W-1:0] nxtVec;

  assign pinFault = ~errN;

  always_comb begin
    nxtDna = strb.instr & strb.trapDna;
    nxtErr = strb.instr & strb.probePin & pinFault;
    nxtGo  = strb.instr & ~strb.trapDna & ~nxtErr;
    unique case ({nxtDna, nxtErr})
      2'b10:   nxtVec = DnaCode;
      2'b01:   nxtVec = ErrCode;
      default: nxtVec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      devNaReq   <= 1'b0;
      coprErrReq <= 1'b0;
      proceed    <= 1'b0;
      excVec     <= '0;
    end else begin
      devNaReq   <= nxtDna;
      coprErrReq <= nxtErr;
      proceed    <= nxtGo;
      excVec     <= nxtVec;
    end
  end

endmodule

// File: rtl/copgate_top.sv
module copgate_top
  import copgate_pkg::*;
#(
  parameter int VEC_W   = 5,
  parameter int DNA_VEC = 7,
  parameter int ERR_VEC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             escStb,
  input  logic             waitStb,
  input  logic             escChkStb,
  input  logic             emBit,
  input  logic             mpBit,
  input  logic             tsBit,
  input  logic             errN,
  output logic             devNaReq,
  output logic             coprErrReq,
  output logic             proceed,
  output logic [VEC_W-1:0] excVec
);

  gateStrobe_t gateStrb;

  copgate_ctrl u_ctrl (
    .escStb    (escStb),
    .waitStb   (waitStb),
    .escChkStb (escChkStb),
    .emBit     (emBit),
    .mpBit     (mpBit),
    .tsBit     (tsBit),
    .strb      (gateStrb)
  );

  copgate_dp #(
    .VEC_W   (VEC_W),
    .DNA_VEC (DNA_VEC),
    .ERR_VEC (ERR_VEC)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (gateStrb),
    .errN       (errN),
    .devNaReq   (devNaReq),
    .coprErrReq (coprErrReq),
    .proceed    (proceed),
    .excVec     (excVec)
  );

endmodule

// File: rtl/copgate_chk.sv
module copgate_chk #(
  parameter int VEC_W   = 5,
  parameter int DNA_VEC = 7,
  parameter int ERR_VEC = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             escStb,
  input logic             waitStb,
  input logic             escChkStb,
  input logic             emBit,
  input logic             mpBit,
  input logic             tsBit,
  input logic             errN,
  input logic             devNaReq,
  input logic             coprErrReq,
  input logic             proceed,
  input logic [VEC_W-1:0] excVec
);

  assert_em_trap_R1: assert property (@(posedge clk) disable iff (rst)
    (escStb && emBit) |=> (devNaReq && excVec == VEC_W'(DNA_VEC)));

  assert_switch_trap_R2: assert property (@(posedge clk) disable iff (rst)
    ((escStb || waitStb) && mpBit && tsBit) |=> devNaReq);

  assert_wait_err_R3: assert property (@(posedge clk) disable iff (rst)
    (waitStb && !escStb && !emBit && !(mpBit && tsBit) && !errN)
      |=> (coprErrReq && excVec == VEC_W'(ERR_VEC)));

  assert_plain_esc_R4: assert property (@(posedge clk) disable iff (rst)
    (escStb && !escChkStb && !emBit && !(mpBit && tsBit)) |=> proceed);

  assert_wait_em_R5: assert property (@(posedge clk) disable iff (rst)
    (waitStb && !escStb && emBit && !(mpBit && tsBit)) |=> proceed);

  assert_priority_R6: assert property (@(posedge clk) disable iff (rst)
    ((escStb && emBit) || ((escStb || waitStb) && mpBit && tsBit)) |=> !coprErrReq);

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({devNaReq, coprErrReq, proceed}));

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!escStb && !waitStb) |=> !(devNaReq || coprErrReq || proceed));

  assert_vec_R9: assert property (@(posedge clk) disable iff (rst)
    (!devNaReq && !coprErrReq) |-> (excVec == '0));

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!devNaReq && !coprErrReq && !proceed && excVec == '0));

endmodule

bind copgate_top copgate_chk #(
  .VEC_W   (VEC_W),
  .DNA_VEC (DNA_VEC),
  .ERR_VEC (ERR_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .escStb     (escStb),
  .waitStb    (waitStb),
  .escChkStb  (escChkStb),
  .emBit      (emBit),
  .mpBit      (mpBit),
  .tsBit      (tsBit),
  .errN       (errN),
  .devNaReq   (devNaReq),
  .coprErrReq (coprErrReq),
  .proceed    (proceed),
  .excVec     (excVec)
);

// File: tb/sim_copgate_top.sv
`timescale 1ns/1ps
module sim_copgate_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       escStb = 0, waitStb = 0, escChkStb = 0;
  logic       emBit = 0, mpBit = 0, tsBit = 0, errN = 1;
  logic       devNaReq, coprErrReq, proceed;
  logic [4:0] excVec;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // expected values for the outputs after the coming edge
  int    expKind = 0;   // 0 none, 1 vector 7, 2 vector 16, 3 proceed
  string expTag  = "R10";

  always #4 clk = ~clk;   // 125 MHz

  copgate_top u0 (
    .clk(clk), .rst(rst), .escStb(escStb), .waitStb(waitStb),
    .escChkStb(escChkStb), .emBit(emBit), .mpBit(mpBit), .tsBit(tsBit),
    .errN(errN), .devNaReq(devNaReq), .coprErrReq(coprErrReq),
    .proceed(proceed), .excVec(excVec)
  );

  // Behavioural reference: judge the instruction as written in the requirements
  task automatic model();
    if (rst) begin
      expKind = 0; expTag = "R10";
    end else if (!escStb && !waitStb) begin
      expKind = 0; expTag = "R8";
    end else if (escStb) begin
      if (emBit) begin
        expKind = 1;
        expTag = (waitStb) ? "R11" : ((escChkStb && !errN) ? "R6" : "R1");
      end else if (mpBit && tsBit) begin
        expKind = 1;
        expTag = (escChkStb && !errN) ? "R6" : "R2";
      end else if (escChkStb && !errN) begin
        expKind = 2; expTag = waitStb ? "R11" : "R4";
      end else begin
        expKind = 3; expTag = escChkStb ? "R7" : "R4";
      end
    end else begin
      if (mpBit && tsBit) begin
        expKind = 1; expTag = (!emBit && !errN) ? "R6" : "R2";
      end else if (emBit) begin
        expKind = 3; expTag = "R5";
      end else if (!errN) begin
        expKind = 2; expTag = "R3";
      end else begin
        expKind = 3; expTag = "R7";
      end
    end
  endtask

  task automatic compare();
    logic [2:0] wantFlags;
    logic [4:0] wantVec;
    wantFlags = (expKind == 1) ? 3'b100 : (expKind == 2) ? 3'b010 :
                (expKind == 3) ? 3'b001 : 3'b000;
    wantVec   = (expKind == 1) ? 5'd7 : (expKind == 2) ? 5'd16 : 5'd0;
    checks++;
    if ({devNaReq, coprErrReq, proceed} !== wantFlags || excVec !== wantVec) begin
      fails++;
      $display("FAIL %s: got dna/err/go=%b vec=%0d, expected %b vec=%0d (R9 vector)",
               expTag, {devNaReq, coprErrReq, proceed}, excVec, wantFlags, wantVec);
    end
  endtask

  // one cycle: check the outputs from the last drive, then drive and predict
  task automatic step(input logic r, input logic [6:0] v);
    @(negedge clk);
    compare();
    rst = r;
    {escStb, waitStb, escChkStb, emBit, mpBit, tsBit, errN} = v;
    model();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles, expected under 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // reset state (R10)
    step(1'b1, 7'b0000001);
    step(1'b1, 7'b1000000);
    // exhaustive sweep: esc, wait, chk, em, mp, ts, errN
    for (int i = 0; i < 128; i++) begin
      step(1'b0, 7'(i));
      step(1'b0, 7'b0000001);
    end
    // back-to-back strobes: pulses stay one cycle each (R8)
    step(1'b0, 7'b1001000);   // escape, em -> vector 7 (R1)
    step(1'b0, 7'b0100000);   // WAIT, pin low -> vector 16 (R3)
    step(1'b0, 7'b1000001);   // plain escape -> proceed (R4)
    step(1'b0, 7'b0100001);   // WAIT -> proceed (R7)
    step(1'b0, 7'b1010110);   // checking escape, mp+ts, pin low (R6)
    step(1'b0, 7'b0101000);   // WAIT, em, pin low ignored (R5)
    step(1'b0, 7'b1110000);   // both strobes, checking, pin low (R11)
    step(1'b0, 7'b0000000);   // idle with pin low (R8)
    // reset while strobes active (R10)
    step(1'b1, 7'b0100000);
    step(1'b1, 7'b1001000);
    step(1'b0, 7'b0100000);
    step(1'b0, 7'b0000001);
    step(1'b0, 7'b0000001);
    @(negedge clk);
    compare();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule